// File: doc/BRIEF.md
# Clock Frequency Monitor

The block checks that one clock runs at the expected rate relative to a second one. The monitored clock drives the block itself as `clk`. Its edges are thinned by a selectable prescaler and counted inside a measurement window. A reference signal sets the length of that window. The reference comes either from an external pin or from an internal source. It is synchronised into the `clk` domain and can be debounced by a digital noise filter. It is qualified on a chosen edge type and then divided down so that one window spans many reference edges.

When a window closes, the block latches the count into a readable register and raises a sticky end flag. It compares the latched value against programmable upper and lower bounds and raises a sticky error flag when the value falls outside them. A sticky overflow flag records a counter wrap inside a window. Each flag has its own interrupt enable. An error can instead be routed to a gated reset-request output. Software sets up the block through a small write port and measures by setting the enable bit.

Top module: `clkmon_top`

## Requirements
- R1: After reset every configuration field, both limits, all flags, `measCount`, `liveCount`, `irq` and `rstReq` are zero. While the enable bit is 0, `liveCount` stays 0. Write map: address 0 = control, address 1 = response control, address 2 = upper limit, address 3 = lower limit, address 4 = flag clear. Control bits: [0] enable, [2:1] target prescale, [4:3] reference prescale, [6:5] edge select, [8:7] filter select, [9] external-reference select.
- R2: The target prescale code 0/1/2/3 makes the counter advance once every 1/4/8/32 `clk` cycles. A window of L cycles, with L a multiple of 32, therefore latches L, L/4, L/8 or L/32.
- R3: The reference prescale code 0/1/2/3 makes a window span 32/128/1024/8192 qualified reference edges. The first such group after enabling only opens the first window.
- R4: The edge select code 0 qualifies rising edges of the conditioned reference. Code 1 qualifies falling edges, and codes 2 and 3 qualify both.
- R5: The filter select code 0 turns the filter off. Codes 1/2/3 sample the synchronised reference every 1/4/16 `clk` cycles and accept a new level only after three consecutive equal samples, so a one-cycle glitch is rejected.
- R6: Control bit 9 set takes the reference from `refExt`; clear takes it from `refInt`. The filter acts only on the external path, and the unselected input has no effect.
- R7: When a window closes, its count is latched into `measCount` and the end flag is set. The live counter restarts and the next window measures the same value for the same input.
- R8: The error flag is set at window close exactly when the latched count is greater than the upper limit or less than the lower limit. Counts equal to a limit are not errors.
- R9: The overflow flag is set when the live counter wraps from 0xFFFF to 0 inside a window.
- R10: The flags are sticky. A write to address 4 clears the error flag for bit 0, the end flag for bit 1 and the overflow flag for bit 2. A set and a clear in the same cycle leave the flag set.
- R11: Address 1 bits: [0] error interrupt enable, [1] end interrupt enable, [2] overflow interrupt enable, [3] route error to reset, [4] reset function enable. `irq` is the OR of every enabled flag. The error flag contributes only while bit 3 is 0.
- R12: `rstReq` is high exactly when the error flag is set and bits 3 and 4 of address 1 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitored (target) clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| refExt | input | 1 | External reference input |
| refInt | input | 1 | Internal reference input |
| measCount | output | 16 | Count latched at last window close |
| liveCount | output | 16 | Running window counter |
| errFlag | output | 1 | Sticky limit-violation flag |
| endFlag | output | 1 | Sticky measurement-end flag |
| ovfFlag | output | 1 | Sticky counter-overflow flag |
| irq | output | 1 | Interrupt request |
| rstReq | output | 1 | Reset request |

## Verification
A window close that sets the end flag can fall in the same cycle as a software write that clears it. The bench provokes this without knowing the close cycle. It holds an end-flag clear write active on every cycle across more than one full window. Because set wins, the end flag must be seen high for one cycle after the close, so observing it at least once proves the ordering. Observing it never proves that the clear dropped the event.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  localparam int REF_PRE_W = 13;
  localparam int TAR_PRE_W = 5;
  localparam int FLT_PRE_W = 4;

  typedef struct packed {
    logic       enable;
    logic [1:0] tarDiv;
    logic [1:0] refDiv;
    logic [1:0] edgeSel;
    logic [1:0] filtSel;
    logic       extRef;
  } ctlCfg_t;

  typedef struct packed {
    logic errIe;
    logic endIe;
    logic ovfIe;
    logic errToReset;
    logic rstEn;
  } irqCfg_t;

  typedef struct packed {
    logic idle;
    logic restart;
    logic latch;
    logic count;
    logic tick;
    logic clrErr;
    logic clrEnd;
    logic clrOvf;
  } strobe_t;

  function automatic logic [TAR_PRE_W-1:0] tarMask(input logic [1:0] code);
    case (code)
      2'd0:    return TAR_PRE_W'(0);
      2'd1:    return TAR_PRE_W'(3);
      2'd2:    return TAR_PRE_W'(7);
      default: return TAR_PRE_W'(31);
    endcase
  endfunction

  function automatic logic [REF_PRE_W-1:0] refLast(input logic [1:0] code);
    case (code)
      2'd0:    return REF_PRE_W'(31);
      2'd1:    return REF_PRE_W'(127);
      2'd2:    return REF_PRE_W'(1023);
      default: return REF_PRE_W'(8191);
    endcase
  endfunction

  function automatic logic [FLT_PRE_W-1:0] filtMask(input logic [1:0] code);
    case (code)
      2'd2:    return FLT_PRE_W'(3);
      2'd3:    return FLT_PRE_W'(15);
      default: return FLT_PRE_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
  import clkmon_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              refExt,
  input  logic              refInt,
  output strobe_t           strobes,
  output irqCfg_t           irqCfg,
  output logic [CNT_W-1:0]  upperLim,
  output logic [CNT_W-1:0]  lowerLim
);

  localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_IRQ = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_UPR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_LWR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADDR_CLR = ADDR_W'(4);

  ctlCfg_t ctl;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl      <= '0;
      irqCfg   <= '0;
      upperLim <= '0;
      lowerLim <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTL: begin
          ctl.enable  <= wrData[0];
          ctl.tarDiv  <= wrData[2:1];
          ctl.refDiv  <= wrData[4:3];
          ctl.edgeSel <= wrData[6:5];
          ctl.filtSel <= wrData[8:7];
          ctl.extRef  <= wrData[9];
        end
        ADDR_IRQ: begin
          irqCfg.errIe      <= wrData[0];
          irqCfg.endIe      <= wrData[1];
          irqCfg.ovfIe      <= wrData[2];
          irqCfg.errToReset <= wrData[3];
          irqCfg.rstEn      <= wrData[4];
        end
        ADDR_UPR: upperLim <= wrData;
        ADDR_LWR: lowerLim <= wrData;
        default: ;
      endcase
    end
  end

  logic clrHit;
  assign clrHit = wrEn && (wrAddr == ADDR_CLR);

  // free-running prescalers
  logic [TAR_PRE_W-1:0] tarPre;
  logic [FLT_PRE_W-1:0] fltPre;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tarPre <= '0;
      fltPre <= '0;
    end else begin
      tarPre <= tarPre + TAR_PRE_W'(1);
      fltPre <= fltPre + FLT_PRE_W'(1);
    end
  end

  logic tarTick, sampleTick;
  assign tarTick    = (tarPre & tarMask(ctl.tarDiv)) == '0;
  assign sampleTick = (fltPre & filtMask(ctl.filtSel)) == '0;

  // synchroniser, noise filter, edge qualification
  logic       refSel, syncQ, level, prevLevel, useFilt;
  logic [1:0] syncPipe, hist;
  assign refSel  = ctl.extRef ? refExt : refInt;
  assign syncQ   = syncPipe[1];
  assign useFilt = ctl.extRef && (ctl.filtSel != 2'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe  <= '0;
      hist      <= '0;
      level     <= 1'b0;
      prevLevel <= 1'b0;
    end else begin
      syncPipe  <= {syncPipe[0], refSel};
      prevLevel <= level;
      if (!useFilt) begin
        level <= syncQ;
      end else if (sampleTick) begin
        hist <= {hist[0], syncQ};
        if (hist[0] == syncQ && hist[1] == syncQ) level <= syncQ;
      end
    end
  end

  logic riseEdge, fallEdge, qualEdge;
  assign riseEdge = level & ~prevLevel;
  assign fallEdge = ~level & prevLevel;
  always_comb begin
    case (ctl.edgeSel)
      2'd0:    qualEdge = riseEdge;
      2'd1:    qualEdge = fallEdge;
      default: qualEdge = riseEdge | fallEdge;
    endcase
  end

  // reference prescaler and window arming
  logic [REF_PRE_W-1:0] refPre;
  logic                 armed, refTick;
  assign refTick = ctl.enable && qualEdge && (refPre == refLast(ctl.refDiv));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPre <= '0;
      armed  <= 1'b0;
    end else if (!ctl.enable) begin
      refPre <= '0;
      armed  <= 1'b0;
    end else if (qualEdge) begin
      if (refTick) begin
        refPre <= '0;
        armed  <= 1'b1;
      end else begin
        refPre <= refPre + REF_PRE_W'(1);
      end
    end
  end

  always_comb begin
    strobes.idle    = !ctl.enable;
    strobes.restart = refTick;
    strobes.latch   = refTick && armed;
    strobes.count   = ctl.enable && armed && tarTick && !refTick;
    strobes.tick    = tarTick;
    strobes.clrErr  = clrHit && wrData[0];
    strobes.clrEnd  = clrHit && wrData[1];
    strobes.clrOvf  = clrHit && wrData[2];
  end

endmodule

// File: rtl/clkmon_datapath.sv
module clkmon_datapath
  import clkmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  irqCfg_t          irqCfg,
  input  logic [CNT_W-1:0] upperLim,
  input  logic [CNT_W-1:0] lowerLim,
  output logic [CNT_W-1:0] measCount,
  output logic [CNT_W-1:0] liveCount,
  output logic             errFlag,
  output logic             endFlag,
  output logic             ovfFlag,
  output logic             irq,
  output logic             rstReq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             outOfRange, wrapNow;

  assign outOfRange = (cnt > upperLim) || (cnt < lowerLim);
  assign wrapNow    = strobes.count && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      measCount <= '0;
    end else begin
      if (strobes.idle)         cnt <= '0;
      else if (strobes.restart) cnt <= CNT_W'(strobes.tick);
      else if (strobes.count)   cnt <= cnt + CNT_W'(1);
      if (strobes.latch) measCount <= cnt;
    end
  end

  // sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      endFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      errFlag <= (strobes.latch && outOfRange) || (errFlag && !strobes.clrErr);
      endFlag <= strobes.latch || (endFlag && !strobes.clrEnd);
      ovfFlag <= wrapNow || (ovfFlag && !strobes.clrOvf);
    end
  end

  assign liveCount = cnt;
  assign irq = (errFlag && irqCfg.errIe && !irqCfg.errToReset)
             || (endFlag && irqCfg.endIe)
             || (ovfFlag && irqCfg.ovfIe);
  assign rstReq = errFlag && irqCfg.errToReset && irqCfg.rstEn;

endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
  import clkmon_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              refExt,
  input  logic              refInt,
  output logic [CNT_W-1:0]  measCount,
  output logic [CNT_W-1:0]  liveCount,
  output logic              errFlag,
  output logic              endFlag,
  output logic              ovfFlag,
  output logic              irq,
  output logic              rstReq
);

  strobe_t          strobes;
  irqCfg_t          irqCfg;
  logic [CNT_W-1:0] upperLim, lowerLim;

  clkmon_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .refExt(refExt), .refInt(refInt), .strobes(strobes), .irqCfg(irqCfg),
    .upperLim(upperLim), .lowerLim(lowerLim)
  );

  clkmon_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .irqCfg(irqCfg),
    .upperLim(upperLim), .lowerLim(lowerLim), .measCount(measCount),
    .liveCount(liveCount), .errFlag(errFlag), .endFlag(endFlag),
    .ovfFlag(ovfFlag), .irq(irq), .rstReq(rstReq)
  );

endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             clrEndWr,
  input logic [CNT_W-1:0] measCount,
  input logic [CNT_W-1:0] liveCount,
  input logic             errFlag,
  input logic             endFlag,
  input logic             ovfFlag,
  input logic             irq,
  input logic             rstReq
);

  a_r8_err_only_at_close: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> endFlag);

  a_r12_reset_needs_error: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> errFlag);

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (errFlag || endFlag || ovfFlag));

  a_r10_end_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (endFlag && !clrEndWr) |=> endFlag);

  a_r7_latch_marks_end: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(measCount) |-> endFlag);

  a_r9_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (liveCount == '0));

endmodule

bind clkmon_top clkmon_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN),
  .clrEndWr(wrEn && (wrAddr == ADDR_W'(4)) && wrData[1]),
  .measCount(measCount), .liveCount(liveCount), .errFlag(errFlag),
  .endFlag(endFlag), .ovfFlag(ovfFlag), .irq(irq), .rstReq(rstReq)
);

// File: tb/tb_clkmon_top.sv
module tb_clkmon_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        refExt, refInt;
  logic [15:0] measCount, liveCount;
  logic        errFlag, endFlag, ovfFlag, irq, rstReq;

  int testCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkmon_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .refExt(refExt), .refInt(refInt), .measCount(measCount),
    .liveCount(liveCount), .errFlag(errFlag), .endFlag(endFlag),
    .ovfFlag(ovfFlag), .irq(irq), .rstReq(rstReq)
  );

  // reference stimulus
  int   halfCycles = 4;
  logic useInt = 1'b0;
  logic glitchOn = 1'b0;
  logic refWave = 1'b0;
  assign refExt = useInt ? 1'b0 : refWave;
  assign refInt = useInt ? refWave : 1'b0;

  task automatic waitHalf();
    int k = 0;
    while (k < halfCycles) begin @(negedge clk); k++; end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      refWave = 1'b1;
      if (glitchOn) begin
        waitCyc(halfCycles / 2);
        refWave = 1'b0;
        waitCyc(1);
        refWave = 1'b1;
        waitCyc(halfCycles - halfCycles / 2 - 1);
      end else begin
        waitHalf();
      end
      refWave = 1'b0;
      waitHalf();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [15:0] ctlWord(input logic [1:0] tarDiv, input logic [1:0] refDiv,
                                          input logic [1:0] edgeSel, input logic [1:0] filtSel,
                                          input logic extRef);
    return {6'd0, extRef, filtSel, edgeSel, refDiv, tarDiv, 1'b0};
  endfunction

  task automatic runMeas(input logic [15:0] ctl, output logic [15:0] val);
    int t = 0;
    wr(3'd0, ctl);
    wr(3'd4, 16'h0007);
    wr(3'd0, ctl | 16'h0001);
    while (!endFlag && t < 30000) begin @(negedge clk); t++; end
    val = measCount;
  endtask

  typedef struct packed {
    logic [1:0]  tarDiv;
    logic [1:0]  refDiv;
    logic [1:0]  edgeSel;
    logic [1:0]  filtSel;
    logic        extRef;
    logic [15:0] half;
    logic [15:0] expCount;
    logic [3:0]  tag;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 16'd4,  16'd256,  4'd2},
    '{2'd1, 2'd0, 2'd0, 2'd0, 1'b1, 16'd4,  16'd64,   4'd2},
    '{2'd2, 2'd0, 2'd0, 2'd0, 1'b1, 16'd4,  16'd32,   4'd2},
    '{2'd3, 2'd0, 2'd0, 2'd0, 1'b1, 16'd4,  16'd8,    4'd2},
    '{2'd0, 2'd0, 2'd2, 2'd0, 1'b1, 16'd4,  16'd128,  4'd4},
    '{2'd0, 2'd0, 2'd1, 2'd0, 1'b1, 16'd4,  16'd256,  4'd4},
    '{2'd0, 2'd0, 2'd0, 2'd2, 1'b1, 16'd16, 16'd1024, 4'd5},
    '{2'd0, 2'd0, 2'd0, 2'd3, 1'b1, 16'd64, 16'd4096, 4'd5},
    '{2'd2, 2'd1, 2'd0, 2'd0, 1'b1, 16'd4,  16'd128,  4'd3},
    '{2'd0, 2'd0, 2'd0, 2'd3, 1'b0, 16'd4,  16'd256,  4'd6}
  };

  function automatic string tagName(input logic [3:0] tag);
    case (tag)
      4'd2:    return "R2 target prescale";
      4'd3:    return "R3 reference prescale";
      4'd4:    return "R4 edge select";
      4'd5:    return "R5 filter";
      default: return "R6 source select";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [15:0] val;
    logic [15:0] base;
    logic        seen;
    int          t;

    // R1 reset state
    waitCyc(5);
    check("R1 measCount", measCount, 0);
    check("R1 liveCount", liveCount, 0);
    check("R1 flags", {errFlag, endFlag, ovfFlag}, 0);
    check("R1 irq/rstReq", {irq, rstReq}, 0);
    rstN = 1'b1;
    waitCyc(60);
    check("R1 disabled counter idle", liveCount, 0);
    check("R1 no end while disabled", endFlag, 0);

    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0000);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      halfCycles = int'(VEC[i].half);
      useInt     = !VEC[i].extRef;
      runMeas(ctlWord(VEC[i].tarDiv, VEC[i].refDiv, VEC[i].edgeSel, VEC[i].filtSel, VEC[i].extRef), val);
      check(tagName(VEC[i].tag), val, VEC[i].expCount);
      check("R7 end flag at close", endFlag, 1);
      check("R8 inside limits no error", errFlag, 0);
      wr(3'd0, 16'h0000);
    end
    useInt = 1'b0;
    halfCycles = 4;
    base = ctlWord(2'd0, 2'd0, 2'd0, 2'd0, 1'b1);

    // R7 restart and repeat
    runMeas(base, val);
    check("R7 live counter restarted", liveCount, 1);
    wr(3'd4, 16'h0002);
    t = 0;
    while (!endFlag && t < 2000) begin @(negedge clk); t++; end
    check("R7 second window", measCount, 256);
    wr(3'd0, 16'h0000);

    // R5 glitch rejection
    halfCycles = 8;
    glitchOn = 1'b1;
    runMeas(ctlWord(2'd0, 2'd0, 2'd0, 2'd1, 1'b1), val);
    check("R5 glitch filtered", val, 512);
    wr(3'd0, 16'h0000);
    runMeas(ctlWord(2'd0, 2'd0, 2'd0, 2'd0, 1'b1), val);
    check("R5 glitch unfiltered", val, 256);
    wr(3'd0, 16'h0000);
    glitchOn = 1'b0;
    halfCycles = 4;

    // R8 limit boundaries (count 256)
    wr(3'd2, 16'd255); wr(3'd3, 16'd0);
    runMeas(base, val);
    check("R8 above upper", errFlag, 1);
    wr(3'd2, 16'd256); wr(3'd3, 16'd256);
    runMeas(base, val);
    check("R8 equal to both limits", errFlag, 0);
    wr(3'd2, 16'd300); wr(3'd3, 16'd257);
    runMeas(base, val);
    check("R8 below lower", errFlag, 1);

    // R11 / R12 routing, error forced
    wr(3'd2, 16'd255); wr(3'd3, 16'd0);
    wr(3'd1, 16'h0001);
    runMeas(base, val);
    check("R11 error interrupt", {irq, rstReq}, 2'b10);
    wr(3'd1, 16'h0019);
    runMeas(base, val);
    check("R12 error to reset", {irq, rstReq}, 2'b01);
    wr(3'd1, 16'h0009);
    runMeas(base, val);
    check("R12 reset gated off", {irq, rstReq}, 2'b00);
    wr(3'd4, 16'h0001);
    check("R10 clear error only", {errFlag, endFlag}, 2'b01);

    // R11 end interrupt and R10 clear
    wr(3'd2, 16'hFFFF);
    wr(3'd1, 16'h0002);
    runMeas(base, val);
    check("R11 end interrupt", irq, 1);
    wr(3'd0, base);
    wr(3'd4, 16'h0002);
    check("R10 end cleared", endFlag, 0);
    check("R11 irq follows clear", irq, 0);

    // R10 set wins over simultaneous clear
    wr(3'd0, base | 16'h0001);
    seen = 1'b0;
    wrAddr = 3'd4; wrData = 16'h0002; wrEn = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (endFlag) seen = 1'b1;
    end
    wrEn = 1'b0;
    check("R10 set beats clear", seen, 1);
    wr(3'd0, 16'h0000);

    // R9 overflow inside a long window
    wr(3'd1, 16'h0004);
    wr(3'd4, 16'h0007);
    wr(3'd0, base | 16'h0001);
    t = 0;
    while (liveCount < 16'd10 && t < 2000) begin @(negedge clk); t++; end
    halfCycles = 2100;
    t = 0;
    while (!ovfFlag && t < 70000) begin @(negedge clk); t++; end
    check("R9 overflow flag", ovfFlag, 1);
    check("R9 overflow interrupt", irq, 1);
    check("R9 no close yet", endFlag, 0);
    check("R9 counter wrapped", liveCount < 16'd64, 1);
    wr(3'd0, 16'h0000);
    halfCycles = 4;

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule